// File: doc/BRIEF.md
# Accumulator ALU with Carry Flag

This block is the arithmetic heart of a small 8-bit processor. It holds the accumulator and a single carry/no-borrow flag, and it executes the sixteen opcodes of one opcode group (upper nibble `F` by default). The sequencer fetches the operand byte itself and hands it to the block together with the opcode and a one-cycle execute strobe. The operand is either the byte addressed by the data pointer or the immediate byte that follows the opcode.

On the clock edge that samples the strobe, the block writes the new accumulator and flag values. On the same edge it raises a one-cycle pulse, `rp_step_o`, which tells the sequencer to move the program pointer past an immediate byte. Opcodes outside the group, and cycles without the strobe, leave the architectural state untouched. Memory access and address arithmetic belong to the sequencer.

Subtraction is available in both operand orders. After any add or subtract, the flag carries the adder's carry-out, so after a subtraction a 1 means "no borrow": the minuend was greater than or equal to the subtrahend. The two shifts move the bit that falls off the end into the flag.

Top module: `acc_alu_core`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the flag and the step pulse to 0.
- R2: Low nibble 0 (data-pointer operand) and 8 (immediate operand) load the operand into the accumulator and leave the flag unchanged.
- R3: Low nibbles 1/9, 2/A and 3/B write operand OR, AND and XOR accumulator into the accumulator and leave the flag unchanged.
- R4: Low nibbles 4/C add the operand to the accumulator. The low DATA_W bits of the sum go to the accumulator and the carry-out goes to the flag.
- R5: Low nibbles 5/D write operand minus accumulator (modulo 2^DATA_W) into the accumulator. The flag becomes 1 exactly when operand >= accumulator.
- R6: Low nibbles 7/F write accumulator minus operand (modulo 2^DATA_W) into the accumulator. The flag becomes 1 exactly when accumulator >= operand.
- R7: Low nibble 6 shifts the accumulator right by one, with 0 entering the top bit and the old bit 0 going to the flag.
- R8: Low nibble E shifts the accumulator left by one, with 0 entering bit 0 and the old top bit going to the flag.
- R9: `rp_step_o` is 1 for the single cycle after an executed group opcode whose low nibble has bit 3 set, except nibble E. It is 0 after nibbles 0 to 7 and 0 in every other cycle.
- R10: An opcode whose upper nibble differs from GROUP_NIB, or any cycle with `exec_i` low, leaves the accumulator and the flag unchanged.
- R11: The results of an executed opcode are visible at the outputs right after the clock edge that samples `exec_i`, so back-to-back opcodes chain through the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Execute strobe for the opcode and operand presented this cycle |
| opcode_i | input | 8 | Full opcode byte |
| operand_i | input | DATA_W | Operand byte, fetched from data memory or as an immediate |
| acc_o | output | DATA_W | Accumulator |
| flag_o | output | 1 | Carry / no-borrow / shifted-out bit |
| rp_step_o | output | 1 | One-cycle request to advance the program pointer past an immediate |

## Verification
The bench builds the block with DATA_W = 4. With that width, every accumulator value, every operand value and both starting flag values can be swept against all sixteen group opcodes within the cycle limit. Every carry boundary, every equal-operand subtraction and every shifted-out top and bottom bit is therefore reached. All fifteen foreign upper nibbles are also swept with the strobe high, and an idle cycle with a live group opcode is checked to show that the state holds.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OPC_W = 8;
  localparam int NIB_W = 4;

  typedef enum logic [3:0] {
    OP_LOAD,
    OP_OR,
    OP_AND,
    OP_XOR,
    OP_ADD,
    OP_SUB_REV,   // operand - acc
    OP_SUB_FWD,   // acc - operand
    OP_SHR,
    OP_SHL
  } alu_op_e;

  typedef struct packed {
    logic    hit;     // opcode belongs to the group
    alu_op_e op;
    logic    imm;     // operand came from the instruction stream
  } dec_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
#(
  parameter logic [NIB_W-1:0] GROUP_NIB = 4'hF
) (
  input  logic [OPC_W-1:0] opcode,
  output dec_t             dec
);

  logic [NIB_W-1:0] hi_nib;
  logic [NIB_W-1:0] lo_nib;

  assign hi_nib = opcode[OPC_W-1:NIB_W];
  assign lo_nib = opcode[NIB_W-1:0];

  always_comb begin
    dec.hit = (hi_nib == GROUP_NIB);
    unique case (lo_nib[2:0])
      3'd0: dec.op = OP_LOAD;
      3'd1: dec.op = OP_OR;
      3'd2: dec.op = OP_AND;
      3'd3: dec.op = OP_XOR;
      3'd4: dec.op = OP_ADD;
      3'd5: dec.op = OP_SUB_REV;
      3'd6: dec.op = lo_nib[3] ? OP_SHL : OP_SHR;
      default: dec.op = OP_SUB_FWD;
    endcase
    // shifts take no operand byte, so they never consume an immediate
    dec.imm = lo_nib[3] && (lo_nib[2:0] != 3'd6);
  end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opd,
  output logic [DATA_W-1:0] res
);

  always_comb begin
    unique case (op)
      OP_LOAD: res = opd;
      OP_OR:   res = acc | opd;
      OP_AND:  res = acc & opd;
      OP_XOR:  res = acc ^ opd;
      default: res = acc;
    endcase
  end

endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opd,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic [DATA_W-1:0] shv,
  output logic              shout
);

  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] a_in;
  logic [DATA_W-1:0] b_in;
  logic              cin;
  logic [SUM_W-1:0]  total;

  // one shared adder: a + (b or ~b) + cin
  always_comb begin
    a_in = acc;
    b_in = opd;
    cin  = 1'b0;
    unique case (op)
      OP_SUB_REV: begin
        a_in = opd;
        b_in = ~acc;
        cin  = 1'b1;
      end
      OP_SUB_FWD: begin
        b_in = ~opd;
        cin  = 1'b1;
      end
      default: ;
    endcase
  end

  assign total = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, cin};
  assign sum   = total[DATA_W-1:0];
  assign cout  = total[DATA_W];

  always_comb begin
    if (op == OP_SHL) begin
      shv   = {acc[DATA_W-2:0], 1'b0};
      shout = acc[DATA_W-1];
    end else begin
      shv   = {1'b0, acc[DATA_W-1:1]};
      shout = acc[0];
    end
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int               DATA_W    = 8,
  parameter logic [NIB_W-1:0] GROUP_NIB = 4'hF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_i,
  input  logic [7:0]        opcode_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              flag_o,
  output logic              rp_step_o
);

  dec_t              dec;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] sum;
  logic              cout;
  logic [DATA_W-1:0] shv;
  logic              shout;
  logic [DATA_W-1:0] acc_nxt;
  logic              flag_nxt;
  logic              fire;

  acc_alu_decode #(.GROUP_NIB(GROUP_NIB)) u_dec (
    .opcode (opcode_i),
    .dec    (dec)
  );

  acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op  (dec.op),
    .acc (acc_o),
    .opd (operand_i),
    .res (logic_res)
  );

  acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op    (dec.op),
    .acc   (acc_o),
    .opd   (operand_i),
    .sum   (sum),
    .cout  (cout),
    .shv   (shv),
    .shout (shout)
  );

  assign fire = exec_i && dec.hit;

  always_comb begin
    unique case (dec.op)
      OP_ADD, OP_SUB_REV, OP_SUB_FWD: begin
        acc_nxt  = sum;
        flag_nxt = cout;
      end
      OP_SHR, OP_SHL: begin
        acc_nxt  = shv;
        flag_nxt = shout;
      end
      default: begin
        acc_nxt  = logic_res;
        flag_nxt = flag_o;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o     <= '0;
      flag_o    <= 1'b0;
      rp_step_o <= 1'b0;
    end else begin
      rp_step_o <= fire && dec.imm;
      if (fire) begin
        acc_o  <= acc_nxt;
        flag_o <= flag_nxt;
      end
    end
  end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int         DATA_W    = 8,
  parameter logic [3:0] GROUP_NIB = 4'hF
) (
  input logic              clk,
  input logic              rst,
  input logic              exec_i,
  input logic [7:0]        opcode_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [DATA_W-1:0] acc_o,
  input logic              flag_o,
  input logic              rp_step_o
);

  logic in_grp;
  logic [2:0] lo3;
  assign in_grp = exec_i && (opcode_i[7:4] == GROUP_NIB);
  assign lo3    = opcode_i[2:0];

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (acc_o == '0) && !flag_o && !rp_step_o);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_grp |=> $stable(acc_o) && $stable(flag_o) && !rp_step_o);

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    in_grp && lo3 == 3'd0 |=> acc_o == $past(operand_i) && $stable(flag_o));

  a_r4_add: assert property (@(posedge clk) disable iff (rst)
    in_grp && lo3 == 3'd4 |=>
      {flag_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(operand_i)}));

  a_r5_sub_rev: assert property (@(posedge clk) disable iff (rst)
    in_grp && lo3 == 3'd5 |=>
      acc_o == DATA_W'($past(operand_i) - $past(acc_o)) &&
      flag_o == ($past(operand_i) >= $past(acc_o)));

  a_r6_sub_fwd: assert property (@(posedge clk) disable iff (rst)
    in_grp && lo3 == 3'd7 |=>
      acc_o == DATA_W'($past(acc_o) - $past(operand_i)) &&
      flag_o == ($past(acc_o) >= $past(operand_i)));

  a_r7_shr: assert property (@(posedge clk) disable iff (rst)
    in_grp && opcode_i[3:0] == 4'h6 |=>
      acc_o == ($past(acc_o) >> 1) && flag_o == $past(acc_o[0]));

  a_r8_shl: assert property (@(posedge clk) disable iff (rst)
    in_grp && opcode_i[3:0] == 4'hE |=>
      acc_o == DATA_W'($past(acc_o) << 1) && flag_o == $past(acc_o[DATA_W-1]));

  a_r9_step: assert property (@(posedge clk) disable iff (rst)
    in_grp |=> rp_step_o == ($past(opcode_i[3]) && $past(opcode_i[3:0]) != 4'hE));

endmodule

bind acc_alu_core acc_alu_chk #(.DATA_W(DATA_W), .GROUP_NIB(GROUP_NIB)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .exec_i    (exec_i),
  .opcode_i  (opcode_i),
  .operand_i (operand_i),
  .acc_o     (acc_o),
  .flag_o    (flag_o),
  .rp_step_o (rp_step_o)
);

// File: tb/acc_alu_core_bench.sv
module acc_alu_core_bench;

  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         exec_i = 1'b0;
  logic [7:0]   opcode_i = 8'h00;
  logic [W-1:0] operand_i = '0;
  logic [W-1:0] acc_o;
  logic         flag_o;
  logic         rp_step_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  acc_alu_core #(.DATA_W(W), .GROUP_NIB(4'hF)) u_acc_alu_core (
    .clk       (clk),
    .rst       (rst),
    .exec_i    (exec_i),
    .opcode_i  (opcode_i),
    .operand_i (operand_i),
    .acc_o     (acc_o),
    .flag_o    (flag_o),
    .rp_step_o (rp_step_o)
  );

  task automatic check(string rq, int ea, int ef, int es);
    checks++;
    if (int'(acc_o) != ea || int'(flag_o) != ef || int'(rp_step_o) != es) begin
      fails++;
      $display("FAIL %s: acc=%0d flag=%0d step=%0d expected acc=%0d flag=%0d step=%0d",
               rq, acc_o, flag_o, rp_step_o, ea, ef, es);
    end
  endtask

  // drive at the falling edge, result is registered at the next rising edge
  task automatic issue(logic [7:0] opc, int opd);
    exec_i    = 1'b1;
    opcode_i  = opc;
    operand_i = W'(opd);
    @(negedge clk);
    exec_i    = 1'b0;
  endtask

  function automatic string req_of(int n);
    case (n)
      0, 8:  return "R2";
      1, 2, 3, 9, 10, 11: return "R3";
      4, 12: return "R4";
      5, 13: return "R5";
      7, 15: return "R6";
      6:     return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog: run did not complete, actual cycles=%0d expected below 150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int ea, ef, es;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", 0, 0, 0);

    // full sweep: starting flag x accumulator x operand x low nibble
    for (int f0 = 0; f0 < 2; f0++) begin
      for (int n = 0; n < 16; n++) begin
        for (int a = 0; a <= MASK; a++) begin
          for (int b = 0; b <= MASK; b++) begin
            issue(8'hF8, f0 << (W - 1));   // top bit = wanted flag
            issue(8'hFE, 0);               // shift it into the flag
            issue(8'hF0, a);
            ef = f0;
            es = ((n & 8) != 0 && n != 14) ? 1 : 0;
            case (n & 7)
              0: ea = b;
              1: ea = a | b;
              2: ea = a & b;
              3: ea = a ^ b;
              4: begin ea = (a + b) & MASK; ef = (a + b) >> W; end
              5: begin ea = (b - a) & MASK; ef = (b >= a) ? 1 : 0; end
              7: begin ea = (a - b) & MASK; ef = (a >= b) ? 1 : 0; end
              default: begin
                if (n == 14) begin ea = (a << 1) & MASK; ef = (a >> (W - 1)) & 1; end
                else         begin ea = a >> 1;          ef = a & 1; end
              end
            endcase
            issue(8'hF0 | 8'(n), b);
            check($sformatf("%s op=F%0h a=%0d b=%0d f=%0d", req_of(n), n, a, b, f0), ea, ef, es);
          end
        end
      end
    end

    // back-to-back chain (R11): load 3, add 5, subtract 2 from it
    issue(8'hF8, 3);
    check("R11 chain load, R9 step after immediate", 3, ef, 1);
    issue(8'hF4, 5);
    check("R11 chain add, R9 no step", 8, 0, 0);
    issue(8'hFF, 2);
    check("R11 chain sub", 6, 1, 1);

    // foreign groups leave state alone (R10)
    issue(8'hF8, 9);
    issue(8'hFA, 9);   // acc 9, flag still 1
    for (int hi = 0; hi < 15; hi++) begin
      for (int lo = 0; lo < 16; lo++) begin
        issue(8'((hi << 4) | lo), 5);
        check($sformatf("R10 foreign opcode %0h%0h", hi, lo), 9, 1, 0);
      end
    end

    // strobe low with a live group opcode (R10)
    exec_i = 1'b0; opcode_i = 8'hF4; operand_i = W'(7);
    @(negedge clk);
    check("R10 strobe low", 9, 1, 0);

    // mid-run reset (R1)
    rst = 1'b1;
    issue(8'hF8, 3);
    rst = 1'b0;
    check("R1 reset mid-run", 0, 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule